// File: doc/BRIEF.md
# DMA Channel Address Generator with Ring Wrap

This block produces the read address and the write address of one DMA channel, and it conditions the data word that the channel moves. A load strobe copies two start addresses into the address registers. After that, each step strobe marks one finished transfer. On a step, each side whose increment is enabled advances by the transfer size in bytes. A side whose increment is off keeps the same address for every transfer.

One side can be limited to a naturally aligned ring of 2^n bytes. A single select bit picks the read side or the write side for the ring. On the ring side, only the low n address bits change, so the address wraps inside an aligned ring buffer. The other side always advances linearly. A ring field of zero turns wrapping off. The data path can reverse byte order, and how it does so depends on the transfer size. Bus handshake and request pacing are handled elsewhere.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released, both rd_addr and wr_addr read 0.
- R2: A cycle with load high copies rd_start and wr_start into rd_addr and wr_addr, visible after that clock edge. Load wins over a step given in the same cycle.
- R3: On a step with load low, a side whose increment enable is high advances by the transfer size. The xfer_size codes are 0 for byte (+1), 1 for halfword (+2) and 2 for word (+4). Code 3 acts as word.
- R4: On a step, a side whose increment enable is low keeps its address unchanged.
- R5: In a cycle with step and load both low, neither address changes.
- R6: A ring_bits value of 0 disables wrapping. The selected side then advances linearly across any boundary.
- R7: For ring_bits n from 1 to 15 on the selected side, a step changes only address bits [n-1:0]. The offset wraps modulo 2^n inside the aligned 2^n-byte region.
- R8: ring_on_write = 0 applies the ring to the read side, and ring_on_write = 1 applies it to the write side. The other side always advances linearly.
- R9: With swap_en low, or with xfer_size = 0, data_out equals data_in.
- R10: With swap_en high and xfer_size = 1, the two bytes of each halfword are exchanged: data_out = {in[23:16], in[31:24], in[7:0], in[15:8]}.
- R11: With swap_en high and xfer_size = 2 or 3, the four bytes are reversed: data_out = {in[7:0], in[15:8], in[23:16], in[31:24]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Copy the start addresses into the address registers |
| rd_start | input | 32 | Read start address |
| wr_start | input | 32 | Write start address |
| xfer_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word (3 acts as word) |
| rd_inc_en | input | 1 | Advance the read address on each step |
| wr_inc_en | input | 1 | Advance the write address on each step |
| ring_bits | input | 4 | Ring size exponent n; 0 disables wrapping |
| ring_on_write | input | 1 | 0: ring applies to the read side; 1: ring applies to the write side |
| swap_en | input | 1 | Enable byte-order reversal for the transfer size |
| step | input | 1 | One transfer completed; advance the addresses |
| data_in | input | 32 | Data word from the read side |
| rd_addr | output | 32 | Current read address |
| wr_addr | output | 32 | Current write address |
| data_out | output | 32 | Data word after optional byte reversal |

## Verification
The assertions check these rules on every cycle:
- a load takes effect, and wins over a step in the same cycle;
- a step with increment off, or no step at all, leaves an address unchanged;
- a linear side advances by exactly the size in bytes;
- a ring side never changes bits at or above position n;
- each swap mode gives its byte permutation.

Only the bench scenarios can show the actual wrap points, with concrete values. These cover a word ring that rolls from the top of a 16-byte region back to its base, a halfword ring on the write side, the largest ring, and a zero ring field that runs linearly across a boundary. The scenarios also show that the select bit moves the ring from one side to the other while the opposite side keeps running linearly.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } xfer_size_e;

    typedef enum logic {
        SIDE_RD = 1'b0,
        SIDE_WR = 1'b1
    } side_e;

    localparam int NUM_SIDES = 2;
    localparam int STEP_W    = 3;

    typedef struct packed {
        logic              load;
        logic              step;
        logic              inc_en;
        logic              ring_en;
        logic [STEP_W-1:0] step_bytes;
    } side_ctrl_t;

    function automatic logic [STEP_W-1:0] size_to_bytes(input xfer_size_e sz);
        case (sz)
            SZ_BYTE: size_to_bytes = 3'd1;
            SZ_HALF: size_to_bytes = 3'd2;
            default: size_to_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_side.sv
module dma_addr_side
    import dma_agen_pkg::*;
#(
    parameter int AW = 32,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  side_ctrl_t    ctrl,
    input  logic [AW-1:0] start,
    input  logic [RW-1:0] ring_bits,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] sum;
    logic [AW-1:0] mask;
    logic [AW-1:0] wrapped;
    logic [AW-1:0] next_addr;
    logic          use_ring;

    always_comb begin
        sum      = addr_q + AW'(ctrl.step_bytes);
        mask     = (AW'(1) << ring_bits) - AW'(1);
        use_ring = ctrl.ring_en && (ring_bits != '0);
        wrapped  = (addr_q & ~mask) | (sum & mask);
        if (ctrl.load)
            next_addr = start;
        else if (ctrl.step && ctrl.inc_en)
            next_addr = use_ring ? wrapped : sum;
        else
            next_addr = addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else
            addr_q <= next_addr;
    end

    assign addr = addr_q;

endmodule

// File: rtl/dma_byte_swap.sv
module dma_byte_swap
    import dma_agen_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic       swap_en,
    input  xfer_size_e size,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    localparam int NB = DW / 8;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        localparam int HSRC = i ^ 1;
        localparam int WSRC = (i & ~3) | (3 - (i & 3));
        always_comb begin
            if (!swap_en || size == SZ_BYTE)
                dout[8*i +: 8] = din[8*i +: 8];
            else if (size == SZ_HALF)
                dout[8*i +: 8] = din[8*HSRC +: 8];
            else
                dout[8*i +: 8] = din[8*WSRC +: 8];
        end
    end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_agen_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] rd_start,
    input  logic [AW-1:0] wr_start,
    input  logic [1:0]    xfer_size,
    input  logic          rd_inc_en,
    input  logic          wr_inc_en,
    input  logic [RW-1:0] ring_bits,
    input  logic          ring_on_write,
    input  logic          swap_en,
    input  logic          step,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] data_out
);

    xfer_size_e        size;
    logic [STEP_W-1:0] nbytes;
    side_ctrl_t        ctrl   [NUM_SIDES];
    logic [AW-1:0]     starts [NUM_SIDES];
    logic [AW-1:0]     addrs  [NUM_SIDES];
    logic              incs   [NUM_SIDES];

    assign size      = xfer_size_e'(xfer_size);
    assign nbytes    = size_to_bytes(size);
    assign starts[0] = rd_start;
    assign starts[1] = wr_start;
    assign incs[0]   = rd_inc_en;
    assign incs[1]   = wr_inc_en;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        always_comb begin
            ctrl[s].load       = load;
            ctrl[s].step       = step;
            ctrl[s].inc_en     = incs[s];
            ctrl[s].ring_en    = (ring_on_write == side_e'(s));
            ctrl[s].step_bytes = nbytes;
        end

        dma_addr_side #(.AW(AW), .RW(RW)) u_side (
            .clk       (clk),
            .rst       (rst),
            .ctrl      (ctrl[s]),
            .start     (starts[s]),
            .ring_bits (ring_bits),
            .addr      (addrs[s])
        );
    end

    assign rd_addr = addrs[0];
    assign wr_addr = addrs[1];

    dma_byte_swap #(.DW(DW)) u_swap (
        .swap_en (swap_en),
        .size    (size),
        .din     (data_in),
        .dout    (data_out)
    );

endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          load,
    input logic [AW-1:0] rd_start,
    input logic [AW-1:0] wr_start,
    input logic [1:0]    xfer_size,
    input logic          rd_inc_en,
    input logic          wr_inc_en,
    input logic [RW-1:0] ring_bits,
    input logic          ring_on_write,
    input logic          swap_en,
    input logic          step,
    input logic [DW-1:0] data_in,
    input logic [AW-1:0] rd_addr,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] data_out
);

    logic [AW-1:0] inc_amt;
    logic          rd_ring;
    logic          wr_ring;

    always_comb begin
        case (xfer_size)
            2'd0:    inc_amt = AW'(1);
            2'd1:    inc_amt = AW'(2);
            default: inc_amt = AW'(4);
        endcase
        rd_ring = !ring_on_write && ring_bits != '0;
        wr_ring =  ring_on_write && ring_bits != '0;
    end

    // R2
    assert_load_rd_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> rd_addr == $past(rd_start));
    assert_load_wr_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> wr_addr == $past(wr_start));

    // R3, R6, R8: a linear side advances by the transfer size
    assert_rd_linear_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !load && rd_inc_en && !rd_ring) |=>
        rd_addr == $past(rd_addr) + $past(inc_amt));
    assert_wr_linear_R8: assert property (@(posedge clk) disable iff (rst)
        (step && !load && wr_inc_en && !wr_ring) |=>
        wr_addr == $past(wr_addr) + $past(inc_amt));

    // R4
    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && !rd_inc_en) |=> $stable(rd_addr));
    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && !wr_inc_en) |=> $stable(wr_addr));

    // R5
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> ($stable(rd_addr) && $stable(wr_addr)));

    // R7: high bits fixed on the ring side
    assert_rd_ring_R7: assert property (@(posedge clk) disable iff (rst)
        (step && !load && rd_ring) |=>
        (rd_addr >> $past(ring_bits)) == ($past(rd_addr) >> $past(ring_bits)));
    assert_wr_ring_R7: assert property (@(posedge clk) disable iff (rst)
        (step && !load && wr_ring) |=>
        (wr_addr >> $past(ring_bits)) == ($past(wr_addr) >> $past(ring_bits)));

    // R9, R10, R11
    assert_swap_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (!swap_en || xfer_size == 2'd0) |-> data_out == data_in);
    assert_swap_half_R10: assert property (@(posedge clk) disable iff (rst)
        (swap_en && xfer_size == 2'd1) |->
        data_out[31:16] == {data_in[23:16], data_in[31:24]});
    assert_swap_word_R11: assert property (@(posedge clk) disable iff (rst)
        (swap_en && xfer_size[1]) |->
        data_out[31:0] == {data_in[7:0], data_in[15:8], data_in[23:16], data_in[31:24]});

endmodule

bind dma_addr_gen dma_addr_gen_chk #(.AW(AW), .DW(DW), .RW(RW)) u_chk (.*);

// File: tb/tb_dma_addr_gen.sv
`timescale 1ns/1ps
module tb_dma_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        load;
    logic [31:0] rd_start, wr_start;
    logic [1:0]  xfer_size;
    logic        rd_inc_en, wr_inc_en;
    logic [3:0]  ring_bits;
    logic        ring_on_write;
    logic        swap_en;
    logic        step;
    logic [31:0] data_in;
    logic [31:0] rd_addr, wr_addr, data_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] m_rd, m_wr;

    always #10 clk = ~clk;

    dma_addr_gen dut (
        .clk(clk), .rst(rst), .load(load), .rd_start(rd_start), .wr_start(wr_start),
        .xfer_size(xfer_size), .rd_inc_en(rd_inc_en), .wr_inc_en(wr_inc_en),
        .ring_bits(ring_bits), .ring_on_write(ring_on_write), .swap_en(swap_en),
        .step(step), .data_in(data_in), .rd_addr(rd_addr), .wr_addr(wr_addr),
        .data_out(data_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    function automatic logic [31:0] adv(input logic [31:0] a, input logic [1:0] sz,
                                        input logic ring, input logic [3:0] n);
        logic [31:0] region;
        if (!ring || n == 0) return a + nbytes(sz);
        region = 32'd1 << n;
        return (a - (a % region)) + ((a + nbytes(sz)) % region);
    endfunction

    task automatic do_load(input logic [31:0] r, input logic [31:0] w);
        @(negedge clk);
        rd_start = r; wr_start = w; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        m_rd = r; m_wr = w;
    endtask

    task automatic do_step(input string tag);
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        if (rd_inc_en) m_rd = adv(m_rd, xfer_size, !ring_on_write, ring_bits);
        if (wr_inc_en) m_wr = adv(m_wr, xfer_size, ring_on_write, ring_bits);
        check({tag, " rd"}, rd_addr, m_rd);
        check({tag, " wr"}, wr_addr, m_wr);
    endtask

    task automatic t_reset;
        rst = 1'b1; load = 0; step = 0; rd_start = 32'hDEAD_0000; wr_start = 32'hBEEF_0000;
        xfer_size = 2'd2; rd_inc_en = 1; wr_inc_en = 1; ring_bits = 0;
        ring_on_write = 0; swap_en = 0; data_in = 0;
        repeat (3) @(negedge clk);
        check("R1 rd in reset", rd_addr, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rd after reset", rd_addr, 32'h0);
        check("R1 wr after reset", wr_addr, 32'h0);
    endtask

    task automatic t_load_linear;
        do_load(32'h0000_1000, 32'h0000_2000);
        check("R2 rd load", rd_addr, 32'h1000);
        check("R2 wr load", wr_addr, 32'h2000);
        xfer_size = 2'd2;
        for (int i = 0; i < 3; i++) do_step("R3 word");
        check("R3 word total", rd_addr, 32'h100C);
        xfer_size = 2'd1; do_step("R3 half");
        check("R3 half wr", wr_addr, 32'h200E);
        xfer_size = 2'd0; do_step("R3 byte");
        check("R3 byte rd", rd_addr, 32'h100F);
        xfer_size = 2'd3; do_step("R3 code3");
        check("R3 code3 rd", rd_addr, 32'h1013);
    endtask

    task automatic t_no_inc;
        do_load(32'h0000_4000, 32'h0000_5000);
        xfer_size = 2'd2; rd_inc_en = 0; wr_inc_en = 1;
        do_step("R4 rd fixed");
        do_step("R4 rd fixed 2");
        check("R4 rd const", rd_addr, 32'h4000);
        rd_inc_en = 1; wr_inc_en = 0;
        do_step("R4 wr fixed");
        check("R4 wr const", wr_addr, 32'h5008);
        wr_inc_en = 1;
    endtask

    task automatic t_idle;
        logic [31:0] r0, w0;
        r0 = rd_addr; w0 = wr_addr;
        repeat (5) @(negedge clk);
        check("R5 rd idle", rd_addr, r0);
        check("R5 wr idle", wr_addr, w0);
    endtask

    task automatic t_load_wins;
        @(negedge clk);
        rd_start = 32'h0000_7770; wr_start = 32'h0000_8880; load = 1; step = 1;
        @(negedge clk);
        load = 0; step = 0;
        m_rd = 32'h7770; m_wr = 32'h8880;
        check("R2 load over step rd", rd_addr, 32'h7770);
        check("R2 load over step wr", wr_addr, 32'h8880);
    endtask

    task automatic t_ring_read;
        ring_on_write = 0; ring_bits = 4'd4; xfer_size = 2'd2;
        do_load(32'h0000_10F8, 32'h0000_20F8);
        do_step("R7 rd ring 1");
        check("R7 rd 10FC", rd_addr, 32'h10FC);
        do_step("R7 rd ring 2");
        check("R7 rd wraps 10F0", rd_addr, 32'h10F0);
        check("R8 wr linear 2100", wr_addr, 32'h2100);
        do_step("R7 rd ring 3");
    endtask

    task automatic t_ring_write;
        ring_on_write = 1; ring_bits = 4'd3; xfer_size = 2'd1;
        do_load(32'h0000_3006, 32'h0000_4006);
        do_step("R8 wr ring");
        check("R8 wr wraps 4000", wr_addr, 32'h4000);
        check("R8 rd linear 3008", rd_addr, 32'h3008);
    endtask

    task automatic t_ring_zero;
        ring_on_write = 0; ring_bits = 4'd0; xfer_size = 2'd2;
        do_load(32'h0000_FFFC, 32'h0000_0000);
        do_step("R6 no wrap");
        check("R6 crosses 10000", rd_addr, 32'h0001_0000);
    endtask

    task automatic t_ring_max;
        ring_on_write = 0; ring_bits = 4'd15; xfer_size = 2'd2;
        do_load(32'h0001_7FFE, 32'h0000_0100);
        do_step("R7 ring15");
        check("R7 ring15 10002", rd_addr, 32'h0001_0002);
        ring_bits = 4'd1; xfer_size = 2'd0;
        do_load(32'h0000_0051, 32'h0);
        do_step("R7 ring1");
        check("R7 ring1 50", rd_addr, 32'h0000_0050);
    endtask

    task automatic t_swap;
        data_in = 32'hA1B2_C3D4;
        swap_en = 0; xfer_size = 2'd2; #1;
        check("R9 swap off", data_out, 32'hA1B2_C3D4);
        swap_en = 1; xfer_size = 2'd0; #1;
        check("R9 byte swap none", data_out, 32'hA1B2_C3D4);
        xfer_size = 2'd1; #1;
        check("R10 half swap", data_out, 32'hB2A1_D4C3);
        xfer_size = 2'd2; #1;
        check("R11 word swap", data_out, 32'hD4C3_B2A1);
        xfer_size = 2'd3; #1;
        check("R11 code3 swap", data_out, 32'hD4C3_B2A1);
        swap_en = 0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_load_linear();
        t_no_inc();
        t_idle();
        t_load_wins();
        t_ring_read();
        t_ring_write();
        t_ring_zero();
        t_ring_max();
        t_swap();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule